// File: doc/BRIEF.md
# XOR-Gated Binary Up-Counter

This block is an 8-bit binary up-counter meant for dividing a clock into several lower rates, or for counting clock periods in a time-measurement path. It is built as a synchronous counter whose outputs step through the same values a ripple counter would. Whether the count advances on a given edge is set by two enable inputs that are combined through an exclusive-OR. When exactly one of them is high, counting stops. When both are high, or both are low, counting runs. The enable pair is captured in a register on every clock edge, and the captured value gates the next edge.

A start override input, when high at a clock edge, makes that edge advance the count whatever the enables say. It works as a level, not as a registered input. A master reset clears the count and the captured enable state at once, without waiting for a clock. It has priority over counting and over the override. The count wraps from its top value back to zero and has no terminal-count output.

Top module: `xgate_counter`

## Requirements
- R1: Each clock edge at which counting is enabled raises `count` by exactly one.
- R2: An enabled edge taken at `count` = 255 gives `count` = 0.
- R3: If `enA` XOR `enB` is 1 at clock edge k, then `count` does not change at edge k+1. This holds unless `startAsync` is high at edge k+1. An enable change that lands at edge k is captured by edge k.
- R4: If `enA` and `enB` are both 1 at edge k, counting is enabled for edge k+1.
- R5: If `enA` and `enB` are both 0 at edge k, counting is enabled for edge k+1.
- R6: When `startAsync` is 1 at a clock edge, `count` advances at that edge, whatever the enables are.
- R7: While `masterRst` is 1, `count` is 0. The clear takes effect at once, with no clock edge needed.
- R8: Reset also clears the captured enable state to "enabled". The first edge after `masterRst` falls therefore advances the count, even if exactly one enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| masterRst | input | 1 | Asynchronous reset, active high; clears the count and the enable state |
| startAsync | input | 1 | Override; when high, the current edge counts regardless of the enables |
| enA | input | 1 | Synchronous enable, first of the XOR pair |
| enB | input | 1 | Synchronous enable, second of the XOR pair |
| count | output | 8 | Present count value |

## Verification
The only internal state besides the count is the one-bit captured enable. If that bit is wrong, the ports show it on the very next edge: the count either holds when it should step, or steps when it should hold. The bench therefore compares the count after every edge of a sequence that stops and restarts counting through both enables, through the override, and through reset. A fault in the toggle chain only appears when the carry reaches a high bit, so the count is run all the way to 255 and across the wrap.

// File: rtl/xgate_counter_pkg.sv
package xgate_counter_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic advance;   // this edge increments the count
  } cntStrobe_t;

endpackage

// File: rtl/xgate_counter_ctrl.sv
module xgate_counter_ctrl
  import xgate_counter_pkg::*;
(
  input  logic       clk,
  input  logic       masterRst,
  input  logic       startAsync,
  input  logic       enA,
  input  logic       enB,
  output cntStrobe_t strobe
);

  logic holdReg;   // 1 = a single enable was seen at the last edge
  logic enMismatch;

  assign enMismatch = enA ^ enB;

  // Capture the XOR of the enables on every edge; reset returns to enabled
  always_ff @(posedge clk or posedge masterRst) begin
    if (masterRst) begin
      holdReg <= 1'b0;
    end else begin
      holdReg <= enMismatch;
    end
  end

  // The override wins over the captured enable state
  always_comb begin
    strobe = '0;
    strobe.advance = startAsync | ~holdReg;
  end

  AST_START_WINS: assert property (@(posedge clk) disable iff (masterRst)
    startAsync |-> strobe.advance); // R6

  AST_SINGLE_EN_GATES: assert property (@(posedge clk) disable iff (masterRst)
    (enMismatch && !startAsync) |=> (!startAsync || strobe.advance) && (startAsync || !strobe.advance)); // R3

endmodule

// File: rtl/xgate_counter_dp.sv
module xgate_counter_dp
  import xgate_counter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             masterRst,
  input  cntStrobe_t       strobe,
  output logic [WIDTH-1:0] count
);

  typedef logic [WIDTH-1:0] cntW_t;

  // carry[i] high: bit i toggles on this edge
  logic [WIDTH:0] carry;

  assign carry[0] = strobe.advance;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign carry[i+1] = carry[i] & count[i];

    always_ff @(posedge clk or posedge masterRst) begin
      if (masterRst) begin
        count[i] <= 1'b0;
      end else if (carry[i]) begin
        count[i] <= ~count[i];
      end
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (masterRst)
    strobe.advance |=> count == cntW_t'($past(count) + 1'b1)); // R1

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (masterRst)
    !strobe.advance |=> $stable(count)); // R3

endmodule

// File: rtl/xgate_counter.sv
module xgate_counter
  import xgate_counter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             masterRst,
  input  logic             startAsync,
  input  logic             enA,
  input  logic             enB,
  output logic [WIDTH-1:0] count
);

  cntStrobe_t strobe;

  xgate_counter_ctrl ctrl_i (
    .clk        (clk),
    .masterRst  (masterRst),
    .startAsync (startAsync),
    .enA        (enA),
    .enB        (enB),
    .strobe     (strobe)
  );

  xgate_counter_dp #(.WIDTH(WIDTH)) dp_i (
    .clk       (clk),
    .masterRst (masterRst),
    .strobe    (strobe),
    .count     (count)
  );

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (masterRst)
    $fell(masterRst) |-> count == '0); // R7

  AST_FIRST_EDGE_RUNS: assert property (@(posedge clk) disable iff (masterRst)
    $fell(masterRst) |=> count == WIDTH'(1)); // R8

endmodule

// File: tb/xgate_counter_tb.sv
module xgate_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic       a;
    logic       b;
    logic       s;
    logic [7:0] exp;
  } vec_t;

  // Inputs applied before an edge, count expected after that edge
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 8'd1},  // R5 neither enable, runs
    '{1'b1, 1'b1, 1'b0, 8'd2},  // R1 both, runs
    '{1'b1, 1'b0, 1'b0, 8'd3},  // R3 single captured, this edge still counts
    '{1'b1, 1'b0, 1'b0, 8'd3},  // R3 hold
    '{1'b0, 1'b1, 1'b0, 8'd3},  // R3 other single, hold
    '{1'b0, 1'b1, 1'b1, 8'd4},  // R6 override counts
    '{1'b0, 1'b1, 1'b0, 8'd4},  // R3 hold again
    '{1'b1, 1'b1, 1'b0, 8'd4},  // R4 both captured, still held this edge
    '{1'b0, 1'b0, 1'b0, 8'd5},  // R4 re-enabled
    '{1'b0, 1'b1, 1'b0, 8'd6},  // R1 counts while capturing single
    '{1'b0, 1'b0, 1'b0, 8'd6},  // R3 held
    '{1'b0, 1'b0, 1'b0, 8'd7}   // R5 re-enabled by neither
  };

  string tagTab [NVEC] = '{"R5", "R1", "R3", "R3", "R3", "R6",
                           "R3", "R4", "R4", "R1", "R3", "R5"};

  logic       clk = 1'b0;
  logic       masterRst;
  logic       startAsync;
  logic       enA;
  logic       enB;
  logic [7:0] count;

  int total = 0;
  int fails = 0;

  xgate_counter dut_i (
    .clk        (clk),
    .masterRst  (masterRst),
    .startAsync (startAsync),
    .enA        (enA),
    .enB        (enB),
    .count      (count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s count=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    fails++;
    $display("FAIL R1 watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    masterRst  = 1'b1;
    startAsync = 1'b0;
    enA        = 1'b0;
    enB        = 1'b0;
    repeat (2) @(negedge clk);
    check("R7", count, 8'd0);
    masterRst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      enA        = VEC[i].a;
      enB        = VEC[i].b;
      startAsync = VEC[i].s;
      @(negedge clk);
      check(tagTab[i], count, VEC[i].exp);
    end

    // R2: run to the top and across the wrap
    enA = 1'b0; enB = 1'b0; startAsync = 1'b0;
    repeat (248) @(negedge clk);
    check("R2", count, 8'd255);
    @(negedge clk);
    check("R2", count, 8'd0);

    // Reset in the middle of a held count
    enA = 1'b1; enB = 1'b0;
    @(negedge clk);
    check("R1", count, 8'd1);
    @(negedge clk);
    check("R3", count, 8'd1);
    #2 masterRst = 1'b1;
    #1 check("R7", count, 8'd0);
    repeat (2) @(negedge clk);
    check("R7", count, 8'd0);
    masterRst = 1'b0;
    @(negedge clk);
    check("R8", count, 8'd1);
    @(negedge clk);
    check("R3", count, 8'd1);
    enB = 1'b1;
    @(negedge clk);
    check("R4", count, 8'd1);
    @(negedge clk);
    check("R4", count, 8'd2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule